// File: doc/BRIEF.md
# Audio Serial Clock Fault Monitor

This block supervises the bit clock and the frame sync of an audio serial port. It samples both clocks with a free-running reference clock. It measures every frame in that reference domain and declares a clock fault in three cases: the frame rate leaves a programmed window, the number of bit clocks in a frame differs from the programmed ratio, or either clock stops for too long. A fault mutes the record path on the next reference cycle.

Recovery waits until every fault condition has cleared and at least one full compliant frame has been measured. The channel gain then climbs back, one unit per programmed number of frames, to the target level it had before the fault. A new fault during the climb mutes the path again at once. The block raises a one-cycle event pulse at the start of each fault episode, meant for a latched status bit and the interrupt request path. It also gives a level fault flag and the gain value applied to the channel.

Top module: `asi_clk_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, gainOut is 0, faultFlag is 0 and faultPulse is 0.
- R2: The frame period is the number of reference cycles between two successive rising edges of the synchronised frame sync. When a measured period is below frameMin or above frameMax, faultFlag rises. Periods equal to frameMin or frameMax are legal.
- R3: The bit clock rising edges counted between two frame sync rising edges must equal bitsPerFrame. If more or fewer are counted, faultFlag rises.
- R4: If either clock shows no rising edge for stallLimit consecutive reference cycles, faultFlag rises. This covers the bit clock alone, the frame sync alone, or both.
- R5: In the cycle after any cycle with faultFlag high, gainOut is 0.
- R6: faultPulse is high for exactly one cycle when faultFlag goes from 0 to 1, and never otherwise. One fault episode gives exactly one pulse.
- R7: After all faults clear, gainOut rises by exactly 1 on every rampFrames-th frame sync edge until it reaches gainTarget. A rampFrames value of 0 acts as 1.
- R8: A fault arising while the gain is ramping returns gainOut to 0 and restarts the ramp from 0 once the fault clears.
- R9: Once the ramp has completed, gainOut follows gainTarget, with one cycle of delay.
- R10: The rate check and the ratio check are evaluated again at every frame sync edge. One compliant frame clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bitClkIn | input | 1 | Audio bit clock, asynchronous |
| frameSyncIn | input | 1 | Audio frame sync, asynchronous |
| frameMin | input | CNT_W | Shortest legal frame period, reference cycles |
| frameMax | input | CNT_W | Longest legal frame period, reference cycles |
| bitsPerFrame | input | RATIO_W | Required bit clock rising edges per frame |
| stallLimit | input | CNT_W | Reference cycles without an edge that count as a stall |
| rampFrames | input | STEP_W | Frames per gain step during recovery |
| gainTarget | input | GAIN_W | Gain level to restore and to hold |
| faultFlag | output | 1 | High while any clock fault condition is present |
| faultPulse | output | 1 | One-cycle event at the start of a fault episode |
| gainOut | output | GAIN_W | Gain applied to the record channel |

## Verification
The assertions assume that each high and low phase of both audio clocks lasts at least two reference cycles, so that every rising edge survives the synchroniser. They also assume a stallLimit above the longest legal frame period and a frame window that is wider than zero. The bench drives both clocks from the reference domain, on the falling edge, and always keeps each phase at two cycles or more. It sets the stall limit to 100 cycles, above the 80-cycle upper frame limit, so the stall check can only fire when a clock has really stopped.

// File: rtl/asi_guard_pkg.sv
package asi_guard_pkg;

  typedef enum logic [1:0] {
    ST_MUTE = 2'd0,
    ST_RAMP = 2'd1,
    ST_RUN  = 2'd2
  } guardState_t;

  // strobes from control to the gain register
  typedef struct packed {
    logic gainClear;
    logic gainStep;
    logic gainLoad;
  } gainCmd_t;

endpackage

// File: rtl/asi_edge_sync.sv
module asi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic riseOut
);

  logic [STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[STAGES-1:0], asyncIn};
  end

  assign riseOut = syncQ[STAGES-1] & ~syncQ[STAGES];

endmodule

// File: rtl/asi_guard_dp.sv
module asi_guard_dp
  import asi_guard_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int RATIO_W = 8,
  parameter int GAIN_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bitClkIn,
  input  logic               frameSyncIn,
  input  logic [CNT_W-1:0]   frameMin,
  input  logic [CNT_W-1:0]   frameMax,
  input  logic [RATIO_W-1:0] bitsPerFrame,
  input  logic [CNT_W-1:0]   stallLimit,
  input  logic [GAIN_W-1:0]  gainTarget,
  input  gainCmd_t           cmd,
  output logic               faultFlag,
  output logic               frameValid,
  output logic               frameTick,
  output logic               gainAtTop,
  output logic [GAIN_W-1:0]  gainOut
);

  localparam int NUM_CLK = 2;  // index 0: bit clock, 1: frame sync
  localparam logic [CNT_W-1:0]   CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [RATIO_W-1:0] RATIO_MAX = {RATIO_W{1'b1}};

  logic [NUM_CLK-1:0] rawIn, riseVec, idleOver;
  assign rawIn = {frameSyncIn, bitClkIn};

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_clk
    logic [CNT_W-1:0] idleCnt;

    asi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .asyncIn (rawIn[i]),
      .riseOut (riseVec[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              idleCnt <= '0;
      else if (riseVec[i])     idleCnt <= '0;
      else if (idleCnt != CNT_MAX) idleCnt <= idleCnt + 1'b1;
    end

    assign idleOver[i] = (idleCnt >= stallLimit);
  end

  logic bcRise, fsRise;
  assign bcRise = riseVec[0];
  assign fsRise = riseVec[1];

  logic [CNT_W-1:0]   periodCnt;
  logic [RATIO_W-1:0] bitCnt;
  logic haveEdgeQ, validQ, rateErrQ, ratioErrQ, stallQ;
  logic [GAIN_W-1:0] gainQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodCnt <= '0;
      bitCnt    <= '0;
      haveEdgeQ <= 1'b0;
      validQ    <= 1'b0;
      rateErrQ  <= 1'b0;
      ratioErrQ <= 1'b0;
      stallQ    <= 1'b0;
    end else begin
      stallQ <= |idleOver;
      if (fsRise) begin
        periodCnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        bitCnt    <= {{(RATIO_W-1){1'b0}}, bcRise};
        haveEdgeQ <= 1'b1;
        if (haveEdgeQ) begin
          rateErrQ  <= (periodCnt < frameMin) || (periodCnt > frameMax);
          ratioErrQ <= (bitCnt != bitsPerFrame);
          validQ    <= 1'b1;
        end
      end else begin
        if (periodCnt != CNT_MAX) periodCnt <= periodCnt + 1'b1;
        if (bcRise && bitCnt != RATIO_MAX) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gainQ <= '0;
    else if (cmd.gainClear) gainQ <= '0;
    else if (cmd.gainLoad)  gainQ <= gainTarget;
    else if (cmd.gainStep)  gainQ <= gainQ + 1'b1;
  end

  assign faultFlag  = rateErrQ | ratioErrQ | stallQ;
  assign frameValid = validQ;
  assign frameTick  = fsRise;
  assign gainAtTop  = ({1'b0, gainQ} + 1'b1) >= {1'b0, gainTarget};
  assign gainOut    = gainQ;

  // R2: a short frame produces a fault
  p_rate_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsRise && haveEdgeQ && periodCnt < frameMin) |=> faultFlag);

  // R3: a wrong bit count produces a fault
  p_ratio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsRise && haveEdgeQ && bitCnt != bitsPerFrame) |=> faultFlag);

  // R4: an idle window of stallLimit cycles produces a fault
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|idleOver) |=> faultFlag);

  // R5: mute on the cycle after a fault
  p_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
    faultFlag |=> (gainQ == '0));

  // R7: gain only climbs by one, or lands on the target
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((gainQ != $past(gainQ)) && (gainQ != '0)) |->
      ((gainQ == $past(gainQ) + 1'b1) || (gainQ == $past(gainTarget))));

endmodule

// File: rtl/asi_guard_ctl.sv
module asi_guard_ctl
  import asi_guard_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              faultFlag,
  input  logic              frameValid,
  input  logic              frameTick,
  input  logic              gainAtTop,
  input  logic [STEP_W-1:0] rampFrames,
  output gainCmd_t          cmd,
  output logic              faultPulse
);

  guardState_t state, stateNext;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W:0]   rampEff;
  logic stepHit, faultQ;

  assign rampEff = (rampFrames == '0) ? {{STEP_W{1'b0}}, 1'b1} : {1'b0, rampFrames};
  assign stepHit = frameTick && (({1'b0, stepCnt} + 1'b1) >= rampEff);

  always_comb begin
    cmd       = '0;
    stateNext = state;
    unique case (state)
      ST_MUTE: begin
        cmd.gainClear = 1'b1;
        if (!faultFlag && frameValid) stateNext = ST_RAMP;
      end
      ST_RAMP: begin
        if (faultFlag) begin
          cmd.gainClear = 1'b1;
          stateNext     = ST_MUTE;
        end else if (stepHit) begin
          if (gainAtTop) begin
            cmd.gainLoad = 1'b1;
            stateNext    = ST_RUN;
          end else begin
            cmd.gainStep = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (faultFlag) begin
          cmd.gainClear = 1'b1;
          stateNext     = ST_MUTE;
        end else begin
          cmd.gainLoad = 1'b1;
        end
      end
      default: begin
        cmd.gainClear = 1'b1;
        stateNext     = ST_MUTE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_MUTE;
      stepCnt <= '0;
      faultQ  <= 1'b0;
    end else begin
      state  <= stateNext;
      faultQ <= faultFlag;
      if (state != ST_RAMP || stepHit) stepCnt <= '0;
      else if (frameTick)              stepCnt <= stepCnt + 1'b1;
    end
  end

  assign faultPulse = faultFlag & ~faultQ;

  // R6: the event never lasts two cycles
  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    faultPulse |=> !faultPulse);

  // R6: the event only comes with the flag
  p_pulse_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    faultPulse |-> faultFlag);

  // R8: a fault during the ramp sends control back to mute
  p_ramp_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAMP && faultFlag) |=> (state == ST_MUTE));

  // R7: no recovery while a fault is present
  p_hold_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUTE && faultFlag) |=> (state == ST_MUTE));

endmodule

// File: rtl/asi_clk_guard.sv
module asi_clk_guard
  import asi_guard_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int RATIO_W = 8,
  parameter int GAIN_W  = 8,
  parameter int STEP_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bitClkIn,
  input  logic               frameSyncIn,
  input  logic [CNT_W-1:0]   frameMin,
  input  logic [CNT_W-1:0]   frameMax,
  input  logic [RATIO_W-1:0] bitsPerFrame,
  input  logic [CNT_W-1:0]   stallLimit,
  input  logic [STEP_W-1:0]  rampFrames,
  input  logic [GAIN_W-1:0]  gainTarget,
  output logic               faultFlag,
  output logic               faultPulse,
  output logic [GAIN_W-1:0]  gainOut
);

  gainCmd_t cmd;
  logic frameValid, frameTick, gainAtTop;

  asi_guard_dp #(
    .CNT_W(CNT_W), .RATIO_W(RATIO_W), .GAIN_W(GAIN_W), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .bitClkIn(bitClkIn), .frameSyncIn(frameSyncIn),
    .frameMin(frameMin), .frameMax(frameMax),
    .bitsPerFrame(bitsPerFrame), .stallLimit(stallLimit),
    .gainTarget(gainTarget), .cmd(cmd),
    .faultFlag(faultFlag), .frameValid(frameValid),
    .frameTick(frameTick), .gainAtTop(gainAtTop),
    .gainOut(gainOut)
  );

  asi_guard_ctl #(.STEP_W(STEP_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .faultFlag(faultFlag), .frameValid(frameValid),
    .frameTick(frameTick), .gainAtTop(gainAtTop),
    .rampFrames(rampFrames), .cmd(cmd),
    .faultPulse(faultPulse)
  );

endmodule

// File: tb/tb_asi_clk_guard.sv
module tb_asi_clk_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // columns: frame period, bits per frame, frames, expected fault, expected gain
  localparam int VEC [0:NVEC-1][0:4] = '{
    '{64,  8, 20, 0, 5},
    '{32,  8,  4, 1, 0},
    '{64,  8, 20, 0, 5},
    '{96,  8,  4, 1, 0},
    '{64,  8, 20, 0, 5},
    '{60, 10,  4, 1, 0},
    '{64,  8, 20, 0, 5},
    '{63,  7,  4, 1, 0},
    '{80,  8, 20, 0, 5},
    '{40,  8, 20, 0, 5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitClkIn = 1'b0, frameSyncIn = 1'b0;
  logic [11:0] frameMin = 12'd40, frameMax = 12'd80, stallLimit = 12'd100;
  logic [7:0]  bitsPerFrame = 8'd8, gainTarget = 8'd5;
  logic [3:0]  rampFrames = 4'd2;
  logic faultFlag, faultPulse;
  logic [7:0] gainOut;

  int nChecks = 0, nFail = 0;
  int pulseCnt = 0, dblPulse = 0, muteErr = 0;
  logic prevFault = 1'b0, prevPulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asi_clk_guard dut (
    .clk(clk), .rst_n(rst_n),
    .bitClkIn(bitClkIn), .frameSyncIn(frameSyncIn),
    .frameMin(frameMin), .frameMax(frameMax),
    .bitsPerFrame(bitsPerFrame), .stallLimit(stallLimit),
    .rampFrames(rampFrames), .gainTarget(gainTarget),
    .faultFlag(faultFlag), .faultPulse(faultPulse), .gainOut(gainOut)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (faultPulse) pulseCnt++;
      if (faultPulse && prevPulse) dblPulse++;
      if (prevFault && gainOut != 8'd0) muteErr++;
      prevFault = faultFlag;
      prevPulse = faultPulse;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runFrames(input int per, input int bits, input int n);
    int g;
    g = per / bits;
    for (int f = 0; f < n; f++)
      for (int c = 0; c < per; c++) begin
        @(negedge clk);
        frameSyncIn = (c < per / 2);
        bitClkIn    = ((c % g) >= g / 2);
      end
  endtask

  task automatic holdIdle(input int n, input bit bcRun);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      frameSyncIn = 1'b0;
      bitClkIn    = bcRun ? ((c % 8) >= 4) : 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int p0, g6, g10;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 gain in reset", gainOut, 0);
    chk("R1 fault in reset", faultFlag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gain after reset", gainOut, 0);
    chk("R1 fault after reset", faultFlag, 0);
    chk("R1 pulse after reset", faultPulse, 0);

    // table: R2 R3 R7 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      p0 = pulseCnt;
      runFrames(VEC[v][0], VEC[v][1], VEC[v][2]);
      chk($sformatf("R2/R3 fault vec %0d", v), faultFlag, VEC[v][3]);
      chk($sformatf("R7/R10 gain vec %0d", v), gainOut, VEC[v][4]);
      chk($sformatf("R6 pulses vec %0d", v), pulseCnt - p0, VEC[v][3]);
    end

    // R7 ramp pacing, rampFrames = 2
    runFrames(32, 8, 4);
    runFrames(64, 8, 6);  g6 = gainOut;
    runFrames(64, 8, 4);  g10 = gainOut;
    chk("R7 gain after 6 frames", g6, 2);
    chk("R7 gain after 10 frames", g10, 4);
    runFrames(64, 8, 12);
    chk("R7 reaches target", gainOut, 5);

    // R7 rampFrames = 0 acts as 1
    rampFrames = 4'd0;
    runFrames(32, 8, 4);
    runFrames(64, 8, 6);
    chk("R7 step every frame", gainOut, 4);
    rampFrames = 4'd2;
    runFrames(64, 8, 10);
    chk("R7 target with fast ramp", gainOut, 5);

    // R8 fault during ramp
    runFrames(32, 8, 4);
    runFrames(64, 8, 6);
    chk("R8 ramp in progress", gainOut, 2);
    runFrames(32, 8, 2);
    chk("R8 fault mid ramp", faultFlag, 1);
    chk("R8 muted mid ramp", gainOut, 0);
    runFrames(64, 8, 20);
    chk("R8 recovered", gainOut, 5);

    // R9 follow target in run state
    gainTarget = 8'd3;
    runFrames(64, 8, 2);
    chk("R9 follows lower target", gainOut, 3);
    gainTarget = 8'd5;
    runFrames(64, 8, 2);
    chk("R9 follows higher target", gainOut, 5);

    // R4 both clocks stopped
    p0 = pulseCnt;
    holdIdle(150, 1'b0);
    chk("R4 stall both fault", faultFlag, 1);
    chk("R4 stall both gain", gainOut, 0);
    runFrames(64, 8, 20);
    chk("R4 recover after stall", gainOut, 5);
    chk("R6 one pulse per stall", pulseCnt - p0, 1);

    // R4 frame sync alone stopped
    p0 = pulseCnt;
    holdIdle(160, 1'b1);
    chk("R4 frame sync stall fault", faultFlag, 1);
    chk("R4 frame sync stall gain", gainOut, 0);
    runFrames(64, 8, 20);
    chk("R4 recover after frame stall", gainOut, 5);
    chk("R6 one pulse per frame stall", pulseCnt - p0, 1);

    // R5 and R6 monitored across the whole run
    chk("R5 gain zero after fault cycle", muteErr, 0);
    chk("R6 no double pulse", dblPulse, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule